// File: doc/BRIEF.md
# Sequence-Validated Kick Gate

This block stands between a program and the clear input of a watchdog counter. A plain kick request is not enough to refresh the watchdog here. The program must pulse an advance strobe at the top of each loop pass. It must then pulse a validate strobe at the bottom of that pass. Each strobe adds a fixed step to its own 16-bit register. The validate also compares the stepped shadow register with the state register. A clear pulse goes out to the watchdog only when the two registers agree and the health input is high.

When the check fails, the clear is withheld so that the watchdog runs out and resets the system. The same happens for a repeated validate, a missing advance, a doubled advance, or both strobes in one cycle. A failed sequence check also sets a flag that stays set until reset. A matching validate while health is low gives a health-error pulse instead of the clear.

Top module: `seq_kick_gate`

## Requirements
- R1: After reset, both internal registers are zero, and kick_o, seq_err_o, health_err_o and seq_fault_o are all low.
- R2: An advance cycle (advance_i=1, validate_i=0) followed later by a validate cycle (validate_i=1, advance_i=0) with health_ok_i=1 makes kick_o high for exactly one cycle, in the cycle after the validate.
- R3: A validate with no advance since the previous validate, or since reset, produces no kick and pulses seq_err_o for one cycle in the cycle after the validate. A validate after two advances behaves the same way.
- R4: After one advance, the first validate kicks and a second validate right after it gives a sequence error and no kick.
- R5: A matching validate with health_ok_i=0 produces no kick and pulses health_err_o for one cycle. It sets no sequence flag, and it still uses up the advance, so the next advance and validate pair kicks.
- R6: advance_i and validate_i high in the same cycle count as a sequence error (seq_err_o pulse, no kick) and leave both registers unchanged. An advance pending before that cycle is therefore still matched by the next validate.
- R7: seq_fault_o is set together with any seq_err_o pulse and stays high until reset.
- R8: Both registers step by 0x1111 and wrap modulo 2^16, so more than 16 correct iterations in a row keep producing kicks.
- R9: An advance alone changes no output. kick_o, seq_err_o and health_err_o are never high together, and each is high only in the cycle after a validate.
- R10: After a sequence mismatch, the registers stay out of step. Later advance and validate pairs produce no kick until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance_i | input | 1 | Start-of-iteration step strobe |
| validate_i | input | 1 | End-of-iteration check strobe |
| health_ok_i | input | 1 | System health verdict, high when healthy |
| kick_o | output | 1 | One-cycle clear pulse to the watchdog |
| seq_err_o | output | 1 | One-cycle sequence-mismatch pulse |
| health_err_o | output | 1 | One-cycle pulse: sequence good, health bad |
| seq_fault_o | output | 1 | Sticky sequence-fault flag |

## Verification
The gate is driven with these strobe patterns:
- clean advance and validate pairs, which show that a kick passes;
- a validate straight after reset, a double validate and a double advance, which each show that a kick is refused;
- both strobes in the same cycle, which shows that the registers are left unchanged because the pending advance still matches afterwards;
- long runs of good iterations, which check the wrap of the 16-bit registers;
- a pair sent while health is low, which separates the health-error path from the sequence-error path;
- pairs sent after a mismatch, which show that the fault stays locked in until reset.

// File: rtl/seq_kick_gate.sv
module seq_kick_gate #(
  parameter int W = 16,
  parameter logic [W-1:0] STEP = 16'h1111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  input  logic validate_i,
  input  logic health_ok_i,
  output logic kick_o,
  output logic seq_err_o,
  output logic health_err_o,
  output logic seq_fault_o
);

  logic [W-1:0] state_q, shadow_q;

  wire adv_only = advance_i & ~validate_i;
  wire val_only = validate_i & ~advance_i;
  wire both     = advance_i & validate_i;

  wire [W-1:0] shadow_step = shadow_q + STEP;
  wire         match       = (shadow_step == state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= '0;
      shadow_q     <= '0;
      kick_o       <= 1'b0;
      seq_err_o    <= 1'b0;
      health_err_o <= 1'b0;
      seq_fault_o  <= 1'b0;
    end else begin
      kick_o       <= 1'b0;
      seq_err_o    <= 1'b0;
      health_err_o <= 1'b0;
      if (adv_only) state_q <= state_q + STEP;
      if (val_only) begin
        shadow_q <= shadow_step;
        if (!match) begin
          seq_err_o   <= 1'b1;
          seq_fault_o <= 1'b1;
        end else if (health_ok_i) begin
          kick_o <= 1'b1;
        end else begin
          health_err_o <= 1'b1;
        end
      end
      if (both) begin
        seq_err_o   <= 1'b1;
        seq_fault_o <= 1'b1;
      end
    end
  end

  assert_outputs_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kick_o, seq_err_o, health_err_o}));

  assert_kick_after_healthy_validate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> $past(validate_i && !advance_i && health_ok_i));

  assert_pulse_needs_validate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err_o || health_err_o) |-> $past(validate_i));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fault_o |=> seq_fault_o);

  assert_err_sets_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |-> seq_fault_o);

  assert_both_no_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && validate_i) |=> (!kick_o && seq_err_o));

endmodule

// File: tb/seq_kick_gate_test.sv
module seq_kick_gate_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advance_i = 1'b0, validate_i = 1'b0, health_ok_i = 1'b1;
  logic kick_o, seq_err_o, health_err_o, seq_fault_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_kick_gate uut (
    .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .validate_i(validate_i),
    .health_ok_i(health_ok_i), .kick_o(kick_o), .seq_err_o(seq_err_o),
    .health_err_o(health_err_o), .seq_fault_o(seq_fault_o)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {kick,seq_err,health_err,fault} got %b expected %b", req, got, exp);
    end
  endtask

  // drive one cycle of strobes at negedge; outputs are sampled at the following negedge
  task automatic cycle(input logic a, input logic v, input logic h);
    advance_i = a; validate_i = v; health_ok_i = h;
    @(negedge clk);
    advance_i = 1'b0; validate_i = 1'b0; health_ok_i = 1'b1;
  endtask

  function automatic logic [3:0] outs();
    return {kick_o, seq_err_o, health_err_o, seq_fault_o};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    advance_i = 1'b0; validate_i = 1'b0; health_ok_i = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state", outs(), 4'b0000);
  endtask

  task automatic t_basic();
    do_reset();
    cycle(1, 0, 1);
    check("R9 advance alone", outs(), 4'b0000);
    cycle(0, 0, 1);
    cycle(0, 1, 1);
    check("R2 kick after pair", outs(), 4'b1000);
    cycle(0, 0, 1);
    check("R2 kick one cycle", outs(), 4'b0000);
  endtask

  task automatic t_no_advance();
    do_reset();
    cycle(0, 1, 1);
    check("R3 validate after reset", outs(), 4'b0101);
    do_reset();
    cycle(1, 0, 1);
    cycle(1, 0, 1);
    cycle(0, 1, 1);
    check("R3 double advance", outs(), 4'b0101);
  endtask

  task automatic t_double_validate();
    do_reset();
    cycle(1, 0, 1);
    cycle(0, 1, 1);
    check("R4 first validate", outs(), 4'b1000);
    cycle(0, 1, 1);
    check("R4 second validate", outs(), 4'b0101);
  endtask

  task automatic t_health();
    do_reset();
    cycle(1, 0, 1);
    cycle(0, 1, 0);
    check("R5 health low", outs(), 4'b0010);
    cycle(1, 0, 1);
    cycle(0, 1, 1);
    check("R5 recovery kick", outs(), 4'b1000);
  endtask

  task automatic t_both();
    do_reset();
    cycle(1, 0, 1);
    cycle(1, 1, 1);
    check("R6 both strobes", outs(), 4'b0101);
    cycle(0, 1, 1);
    check("R6 registers kept", outs(), 4'b1001);
  endtask

  task automatic t_sticky_and_lock();
    do_reset();
    cycle(0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      cycle(1, 0, 1);
      cycle(0, 1, 1);
      check("R10 locked out", outs(), 4'b0101);
    end
    cycle(0, 0, 1);
    check("R7 fault sticky", outs(), 4'b0001);
    do_reset();
    check("R7 fault cleared by reset", outs(), 4'b0000);
  endtask

  task automatic t_wrap();
    int bad = 0;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      cycle(1, 0, 1);
      cycle(0, 1, 1);
      if (outs() !== 4'b1000) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R8 wrap: %0d of 20 iterations wrong, expected 0", bad);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_advance();
    t_double_validate();
    t_health();
    t_both();
    t_sticky_and_lock();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule